// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 14-bit virtual address into a 16-bit physical address. The two upper bits of the virtual address pick one of three segments: code, heap or stack. Each segment has its own base register and its own size register. The twelve lower bits form an offset, which the block checks against the segment's size and then adds to the segment's base. One clock after an access strobe, the block reports either a valid physical address or a fault. A fault comes from an out-of-range offset, an unassigned segment selector, or a sum that does not fit in the physical address width.

Software reaches the segment table through a small register port. The port is used to save and restore the table on every context switch. Any mode may read the table. A write lands only while the kernel-mode input is high. A write attempted in user mode leaves the table untouched and raises a one-cycle privilege error.

Top module: `seg_xlate`

## Requirements
- R1: `acc_vaddr[13:12]` selects the segment (0 code, 1 heap, 2 stack). `acc_vaddr[11:0]` is the offset within that segment.
- R2: When `acc_valid` is high and the access is legal, the next cycle shows `pa_valid` high and `pa_addr` equal to the segment base plus the offset.
- R3: An offset greater than or equal to the selected segment's size gives `pa_fault` high, `pa_valid` low and `pa_addr` zero in the next cycle. An offset of exactly size minus one still translates.
- R4: An access with selector value 3 always faults.
- R5: A base plus offset sum above 0xFFFF faults. A sum of exactly 0xFFFF translates.
- R6: `pa_valid` and `pa_fault` are never high together. Each is high only in the cycle after an `acc_valid` strobe, and exactly one of them is high then. With no strobe, both are low and `pa_addr` is zero.
- R7: `cfg_rdata` shows, in the same cycle and in any mode, the register chosen by `cfg_seg` (0 to 2) and `cfg_sel` (0 base, 1 size). Index 3 reads as zero, and writes to index 3 have no effect.
- R8: A write with `cfg_we` and `kmode` both high updates the addressed register at the clock edge.
- R9: A write with `cfg_we` high and `kmode` low leaves the table unchanged and drives `priv_err` high for the following cycle only.
- R10: After reset, every base and size register reads zero, all outputs are low, and every access faults until the table is programmed.
- R11: When an access and a kernel write to the same segment occur in the same cycle, the access is translated with the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_vaddr | input | 14 | Virtual address: selector in the upper two bits, offset below |
| kmode | input | 1 | 1 = kernel mode, 0 = user mode |
| cfg_we | input | 1 | Register write request |
| cfg_seg | input | 2 | Segment index for register read and write |
| cfg_sel | input | 1 | 0 selects base, 1 selects size |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| pa_valid | output | 1 | Translation succeeded (registered) |
| pa_fault | output | 1 | Translation faulted (registered) |
| pa_addr | output | 16 | Physical address, zero unless `pa_valid` is high |
| priv_err | output | 1 | User-mode write was rejected (registered) |

## Verification
A translation and a register write can fall in the same cycle. This is the case where a context switch reprograms a segment while an access to that segment is still in flight. The bench provokes it by strobing a code-segment access in the same cycle as a kernel write of a new code base. It expects the result computed from the old base, and the next access to use the new base. The bench also pairs a user-mode write with a lawful access in one cycle. It then checks that the translation result and `priv_err` come out together, independently of each other, and that a readback shows the table unchanged.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
    // Register-port field selector
    typedef enum logic {
        FLD_BASE = 1'b0,
        FLD_SIZE = 1'b1
    } seg_fld_e;

    // Segment selector encodings (selector 3 is unassigned)
    localparam logic [1:0] SEG_CODE  = 2'd0;
    localparam logic [1:0] SEG_HEAP  = 2'd1;
    localparam logic [1:0] SEG_STACK = 2'd2;
endpackage

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
module seg_regfile #(
    parameter int SEG_W   = 2,
    parameter int NUM_SEG = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEG_W-1:0]  rd_idx,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SEG_W-1:0]  lk_idx,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_base,
    output logic [DATA_W-1:0] lk_size
);
    import seg_xlate_pkg::*;

    logic [DATA_W-1:0] base_d [NUM_SEG];
    logic [DATA_W-1:0] base_q [NUM_SEG];
    logic [DATA_W-1:0] size_d [NUM_SEG];
    logic [DATA_W-1:0] size_q [NUM_SEG];

    // Next-state: only an addressed, existing entry changes
    always_comb begin
        for (int i = 0; i < NUM_SEG; i++) begin
            base_d[i] = base_q[i];
            size_d[i] = size_q[i];
            if (wr_en && (wr_idx == SEG_W'(i))) begin
                if (wr_sel == FLD_SIZE) size_d[i] = wr_data;
                else                    base_d[i] = wr_data;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_q[g] <= '0;
                    size_q[g] <= '0;
                end else begin
                    base_q[g] <= base_d[g];
                    size_q[g] <= size_d[g];
                end
            end
        end
    endgenerate

    // Software read port and translation lookup port
    always_comb begin
        rd_data = '0;
        lk_hit  = 1'b0;
        lk_base = '0;
        lk_size = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == SEG_W'(i))
                rd_data = (rd_sel == FLD_SIZE) ? size_q[i] : base_q[i];
            if (lk_idx == SEG_W'(i)) begin
                lk_hit  = 1'b1;
                lk_base = base_q[i];
                lk_size = size_q[i];
            end
        end
    end
endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             seg_hit,
    input  logic [PA_W-1:0]  base,
    input  logic [PA_W-1:0]  size,
    input  logic [OFF_W-1:0] offset,
    output logic             ok,
    output logic [PA_W-1:0]  paddr
);
    localparam int SUM_W = PA_W + 1;

    logic [SUM_W-1:0] sum;
    logic             in_range;

    always_comb begin
        sum      = {1'b0, base} + SUM_W'(offset);
        in_range = PA_W'(offset) < size;
        ok       = seg_hit && in_range && !sum[PA_W];
        paddr    = sum[PA_W-1:0];
    end
endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate #(
    parameter int VA_W    = 14,
    parameter int SEG_W   = 2,
    parameter int PA_W    = 16,
    parameter int NUM_SEG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [VA_W-1:0]  acc_vaddr,
    input  logic             kmode,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] cfg_seg,
    input  logic             cfg_sel,
    input  logic [PA_W-1:0]  cfg_wdata,
    output logic [PA_W-1:0]  cfg_rdata,
    output logic             pa_valid,
    output logic             pa_fault,
    output logic [PA_W-1:0]  pa_addr,
    output logic             priv_err
);
    localparam int OFF_W = VA_W - SEG_W;

    typedef struct packed {
        logic            ok;
        logic            bad;
        logic [PA_W-1:0] addr;
        logic            perr;
    } resp_t;

    resp_t r_d, r_q;

    logic             lk_hit;
    logic [PA_W-1:0]  lk_base;
    logic [PA_W-1:0]  lk_size;
    logic             chk_ok;
    logic [PA_W-1:0]  chk_pa;
    logic             wr_allow;

    assign wr_allow = cfg_we && kmode;

    seg_regfile #(
        .SEG_W  (SEG_W),
        .NUM_SEG(NUM_SEG),
        .DATA_W (PA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_allow),
        .wr_idx (cfg_seg),
        .wr_sel (cfg_sel),
        .wr_data(cfg_wdata),
        .rd_idx (cfg_seg),
        .rd_sel (cfg_sel),
        .rd_data(cfg_rdata),
        .lk_idx (acc_vaddr[VA_W-1:OFF_W]),
        .lk_hit (lk_hit),
        .lk_base(lk_base),
        .lk_size(lk_size)
    );

    seg_check #(
        .OFF_W(OFF_W),
        .PA_W (PA_W)
    ) u_check (
        .seg_hit(lk_hit),
        .base   (lk_base),
        .size   (lk_size),
        .offset (acc_vaddr[OFF_W-1:0]),
        .ok     (chk_ok),
        .paddr  (chk_pa)
    );

    always_comb begin
        r_d      = '0;
        r_d.ok   = acc_valid && chk_ok;
        r_d.bad  = acc_valid && !chk_ok;
        r_d.addr = (acc_valid && chk_ok) ? chk_pa : '0;
        r_d.perr = cfg_we && !kmode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pa_valid = r_q.ok;
    assign pa_fault = r_q.bad;
    assign pa_addr  = r_q.addr;
    assign priv_err = r_q.perr;
endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
    parameter int VA_W  = 14,
    parameter int SEG_W = 2,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [VA_W-1:0]  acc_vaddr,
    input logic             kmode,
    input logic             cfg_we,
    input logic [SEG_W-1:0] cfg_seg,
    input logic             cfg_sel,
    input logic [PA_W-1:0]  cfg_rdata,
    input logic             pa_valid,
    input logic             pa_fault,
    input logic [PA_W-1:0]  pa_addr,
    input logic             priv_err
);
    localparam int OFF_W = VA_W - SEG_W;

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_valid && pa_fault)); // R6

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (pa_valid != pa_fault)); // R6

    AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!pa_valid && !pa_fault && pa_addr == '0)); // R6

    AST_BAD_SELECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_vaddr[VA_W-1:OFF_W] == '1) |=> pa_fault); // R4

    AST_ADDR_COVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pa_valid |-> (pa_addr >= PA_W'($past(acc_vaddr[OFF_W-1:0])))); // R2

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        pa_fault |-> (pa_addr == '0)); // R3

    AST_USER_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !kmode) |=> priv_err); // R9

    AST_KERNEL_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !kmode) |=> !priv_err); // R9

    AST_USER_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !kmode) |=>
            ((cfg_rdata == $past(cfg_rdata)) || (cfg_seg != $past(cfg_seg))
             || (cfg_sel != $past(cfg_sel)))); // R9

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!pa_valid && !pa_fault && !priv_err); // R10
        end
    end
endmodule

bind seg_xlate seg_xlate_chk #(
    .VA_W (VA_W),
    .SEG_W(SEG_W),
    .PA_W (PA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_vaddr(acc_vaddr),
    .kmode    (kmode),
    .cfg_we   (cfg_we),
    .cfg_seg  (cfg_seg),
    .cfg_sel  (cfg_sel),
    .cfg_rdata(cfg_rdata),
    .pa_valid (pa_valid),
    .pa_fault (pa_fault),
    .pa_addr  (pa_addr),
    .priv_err (priv_err)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [13:0] acc_vaddr = '0;
    logic        kmode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_seg = '0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        pa_valid;
    logic        pa_fault;
    logic [15:0] pa_addr;
    logic        priv_err;

    seg_xlate i_seg_xlate (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
        .kmode(kmode), .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pa_valid(pa_valid),
        .pa_fault(pa_fault), .pa_addr(pa_addr), .priv_err(priv_err)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        logic        v;
        logic        f;
        logic [15:0] a;
        logic        p;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    // Bench-side model of the segment table (index 3 never written)
    int m_base[4] = '{0, 0, 0, 0};
    int m_size[4] = '{0, 0, 0, 0};

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(input logic a, input logic [13:0] va, input logic we,
                        input logic km, input logic [1:0] cs, input logic csel,
                        input logic [15:0] wd, input string tag);
        exp_t e;
        int   sg, off, sum;
        @(negedge clk);
        acc_valid = a;  acc_vaddr = va; cfg_we = we; kmode = km;
        cfg_seg = cs;   cfg_sel = csel; cfg_wdata = wd;
        sg  = int'(va[13:12]);
        off = int'(va[11:0]);
        sum = m_base[sg] + off;
        e.v = 1'b0; e.f = 1'b0; e.a = '0; e.tag = tag;
        e.p = we && !km;
        if (a) begin
            if (sg == 3 || off >= m_size[sg] || sum > 65535) e.f = 1'b1;
            else begin e.v = 1'b1; e.a = 16'(sum); end
        end
        q.push_back(e);
        if (we && km && cs != 2'd3) begin
            if (csel) m_size[cs] = int'(wd);
            else      m_base[cs] = int'(wd);
        end
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, '0, "R6");
    endtask

    task automatic access(input logic [1:0] sg, input int off, input string tag);
        step(1'b1, {sg, 12'(off)}, 1'b0, 1'b0, 2'd0, 1'b0, '0, tag);
    endtask

    task automatic kwrite(input logic [1:0] sg, input logic sel, input int val);
        step(1'b0, '0, 1'b1, 1'b1, sg, sel, 16'(val), "R8");
    endtask

    task automatic read_chk(input logic [1:0] sg, input logic sel, input logic km,
                            input int exp_val, input string tag);
        step(1'b0, '0, 1'b0, km, sg, sel, '0, tag);
        #2;
        checks++;
        if (cfg_rdata !== 16'(exp_val)) begin
            fails++;
            $display("FAIL %s: read seg%0d sel%0d actual=%h expected=%h",
                     tag, sg, sel, cfg_rdata, 16'(exp_val));
        end
    endtask

    // Monitor: compares each registered result a little after the edge
    always @(posedge clk) begin
        #2;
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pa_valid !== e.v || pa_fault !== e.f || pa_addr !== e.a ||
                priv_err !== e.p) begin
                fails++;
                $display("FAIL %s: actual v=%b f=%b a=%h p=%b expected v=%b f=%b a=%h p=%b",
                         e.tag, pa_valid, pa_fault, pa_addr, priv_err,
                         e.v, e.f, e.a, e.p);
            end
        end
    end

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R10: outputs quiet while in reset
        checks++;
        if (pa_valid !== 1'b0 || pa_fault !== 1'b0 || priv_err !== 1'b0) begin
            fails++;
            $display("FAIL R10: reset outputs actual=%b%b%b expected=000",
                     pa_valid, pa_fault, priv_err);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R10: empty table after reset, every access faults
        read_chk(2'd0, 1'b0, 1'b0, 0, "R10");
        read_chk(2'd2, 1'b1, 1'b0, 0, "R10");
        access(2'd0, 0, "R10");
        access(2'd1, 5, "R10");

        // R8: program the example table in kernel mode
        kwrite(2'd0, 1'b0, 16'h8000); kwrite(2'd0, 1'b1, 16'h0800);
        kwrite(2'd1, 1'b0, 16'h8800); kwrite(2'd1, 1'b1, 16'h0800);
        kwrite(2'd2, 1'b0, 16'h7000); kwrite(2'd2, 1'b1, 16'h0800);
        read_chk(2'd0, 1'b0, 1'b0, 16'h8000, "R8");
        read_chk(2'd1, 1'b1, 1'b0, 16'h0800, "R7");
        read_chk(2'd2, 1'b0, 1'b1, 16'h7000, "R7");

        // R1/R2: translations in each segment, back to back
        access(2'd0, 0, "R2");
        access(2'd1, 16'h07FF, "R3");
        access(2'd1, 16'h0800, "R3");
        access(2'd2, 16'h0123, "R1");
        access(2'd3, 16'h0010, "R4");
        access(2'd0, 16'h0FFF, "R3");
        idle();

        // R9: user-mode write rejected, paired with a lawful access
        step(1'b1, {2'd0, 12'h004}, 1'b1, 1'b0, 2'd0, 1'b0, 16'h1234, "R9");
        idle();
        read_chk(2'd0, 1'b0, 1'b0, 16'h8000, "R9");

        // R5: sum at and past the top of the physical space
        kwrite(2'd2, 1'b0, 16'hFF00);
        kwrite(2'd2, 1'b1, 16'h1000);
        access(2'd2, 16'h00FF, "R5");
        access(2'd2, 16'h0100, "R5");

        // R11: access and base rewrite in the same cycle
        step(1'b1, {2'd0, 12'h010}, 1'b1, 1'b1, 2'd0, 1'b0, 16'h4000, "R11");
        access(2'd0, 16'h0010, "R11");

        // R7: index 3 is not a register
        kwrite(2'd3, 1'b0, 16'hABCD);
        read_chk(2'd3, 1'b0, 1'b1, 0, "R7");
        access(2'd3, 0, "R4");

        repeat (3) idle();
        @(negedge clk);
        summary();
        $finish;
    end
endmodule